// File: doc/BRIEF.md
# Interrupt Control Register with Split Read and Write Views

This block is a byte-wide, memory-mapped interrupt control register for a small computer's I/O controller. Five interrupt sources feed it: gap, IPC, transmit, frame and external. A rising edge on a source sets a pending latch. The CPU reaches the block through one address. A write acknowledges pending interrupts and loads the enable bits. A read returns a live status byte, not the value last written.

The read byte has three parts. The low five bits are the raw pending latches, including any that are masked. Bits 5 and 7 are the free-running RTC and baud-rate reference levels. Bit 6 is an active-low summary of the drive-motor inputs. The register cannot be read back, so software must keep its own copy of the enable bits. An active-low request output tells the CPU when a pending interrupt needs service.

All source, reference and motor inputs are asynchronous. Each passes through a two-stage synchronizer before the block uses it.

Top module: `irq_ctrl_reg`

## Requirements
- R1: While reset is active and just after it, every pending latch and every enable bit is 0. `irq_n` is 1, and with the reference and motor inputs low, `rdata` reads 0x40.
- R2: A 0-to-1 change on `src[k]` sets pending bit k. The bit shows on `rdata[k]` after the third rising clock edge that follows the change, counting the two synchronizer stages and the edge-detect stage.
- R3: Read bits 0 to 4 give the pending state of gap, IPC, transmit, frame and external, in that order. Each bit reads its pending state whether or not that source is enabled.
- R4: `rdata[5]` shows the RTC reference level and `rdata[7]` shows the baud reference level. Each follows its input two clock edges later.
- R5: `rdata[6]` reads 0 when any bit of `motor` is 1 and reads 1 when all bits are 0. It follows the inputs two clock edges later.
- R6: A write (`cs`=1, `wr`=1) with a 1 in data bit k (k from 0 to 4) clears pending bit k. A 0 in bit k leaves it unchanged. Writing 0x1F clears all five.
- R7: If a source edge sets a pending bit on the same clock edge that a write clears it, the bit stays set.
- R8: Every write loads the three enable bits from its data. Bit 5 enables gap, bit 6 enables transmit and bit 7 enables external. A write with bit 5 at 0 disables gap.
- R9: `irq_n` is 0 exactly when one of these holds: some pending gap, transmit or external bit has its enable set, or IPC or frame is pending. IPC and frame have no enable bit.
- R10: A read access (`cs`=1, `wr`=0) changes no pending bit and no enable bit, whatever value is on `wdata`.
- R11: A source pulse that is high for only one clock cycle still sets its pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register select |
| wr | input | 1 | 1 for a write, 0 for a read |
| wdata | input | 8 | Write data: acknowledge bits [4:0], enable bits [7:5] |
| rdata | output | 8 | Status byte |
| src | input | 5 | Interrupt sources: gap, IPC, transmit, frame, external |
| rtc_ref | input | 1 | RTC reference clock |
| baud_ref | input | 1 | Baud-rate reference clock |
| motor | input | N_MOTOR | Drive-motor active flags |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that the bus inputs `cs`, `wr` and `wdata` change only away from the rising clock edge. They also assume that these inputs are stable over the edge at which a write takes effect. The source, reference and motor inputs may change at any time, because the synchronizers absorb the asynchrony.

The bench drives every input on the falling clock edge. A random phase toggles the sources with low probability. This produces single-cycle pulses and sets that coincide with clears, while the bus issues mixed reads and writes.

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int N_MOTOR = 2,
  parameter int N_SRC   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               wr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic [N_SRC-1:0]   src,
  input  logic               rtc_ref,
  input  logic               baud_ref,
  input  logic [N_MOTOR-1:0] motor,
  output logic               irq_n
);
  localparam int SW = N_SRC + N_MOTOR + 2;

  logic [SW-1:0]    s1, s2;
  logic [N_SRC-1:0] src_q, pend, rise, clr, en_map;
  logic [2:0]       en;
  logic             wr_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1    <= '0;
      s2    <= '0;
      src_q <= '0;
    end else begin
      s1    <= {baud_ref, rtc_ref, motor, src};
      s2    <= s1;
      src_q <= s2[N_SRC-1:0];
    end

  assign wr_hit = cs & wr;
  assign rise   = s2[N_SRC-1:0] & ~src_q;
  assign clr    = wr_hit ? wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= (pend & ~clr) | rise;
      if (wr_hit) en <= wdata[7:5];
    end

  assign en_map = {en[2], 1'b1, en[1], 1'b1, en[0]};
  assign irq_n  = ~|(pend & en_map);
  assign rdata  = {s2[SW-1], ~|s2[N_SRC +: N_MOTOR], s2[SW-2], pend};
endmodule

// File: rtl/irq_ctrl_reg_sva.sv
module irq_ctrl_reg_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       wr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq_n,
  input logic [4:0] rise,
  input logic [2:0] en
);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr) |=> ((rdata[4:0] & $past(wdata[4:0] & ~rise)) == 5'd0));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rdata[4:0] & $past(rise)) == $past(rise)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs && wr) && rise == 5'd0) |=> $stable(rdata[4:0]));

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr) |=> $stable(en));

  p_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[1] || rdata[3]) |-> !irq_n);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[4:0] == 5'd0) |-> irq_n);
endmodule

bind irq_ctrl_reg irq_ctrl_reg_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .wdata(wdata),
  .rdata(rdata), .irq_n(irq_n), .rise(rise), .en(en)
);

// File: tb/tb_irq_ctrl_reg.sv
`timescale 1ns/1ps
module tb_irq_ctrl_reg;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cs = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic [4:0] src = 0;
  logic       rtc_ref = 0, baud_ref = 0;
  logic [1:0] motor = 0;
  logic [7:0] rdata;
  logic       irq_n;

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  irq_ctrl_reg dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .wdata(wdata), .rdata(rdata),
    .src(src), .rtc_ref(rtc_ref), .baud_ref(baud_ref), .motor(motor), .irq_n(irq_n)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model: queue of sampled raw inputs, newest first
  logic [7:0] hist[$];
  logic [4:0] m_pend;
  logic [2:0] m_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {8'h00, 8'h00, 8'h00};
      m_pend = 0;
      m_en = 0;
    end else begin
      logic [4:0] r;
      r = hist[1][4:0] & ~hist[2][4:0];
      if (cs && wr) begin
        m_pend = m_pend & ~wdata[4:0];
        m_en = wdata[7:5];
      end
      m_pend = m_pend | r;
      hist.push_front({baud_ref, |motor, rtc_ref, src});
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] exp_rd();
    return {hist[1][7], ~hist[1][6], hist[1][5], m_pend};
  endfunction
  function automatic logic exp_irq();
    return ~|(m_pend & {m_en[2], 1'b1, m_en[1], 1'b1, m_en[0]});
  endfunction

  always @(negedge clk) if (cmp_on && rst_n) begin
    logic [7:0] e;
    e = exp_rd();
    check(rdata[4:0] == e[4:0], "R3 pending", rdata[4:0], e[4:0]);
    check({rdata[7], rdata[5]} == {e[7], e[5]}, "R4 refs", {rdata[7], rdata[5]}, {e[7], e[5]});
    check(rdata[6] == e[6], "R5 motor", rdata[6], e[6]);
    check(irq_n == exp_irq(), "R9 irq", irq_n, exp_irq());
  end

  task automatic wr_byte(input logic [7:0] v);
    @(negedge clk); cs = 1; wr = 1; wdata = v;
    @(negedge clk); cs = 0; wr = 0; wdata = 0;
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check(rdata == 8'h40 && irq_n == 1, "R1 reset", {irq_n, rdata}, 9'h140);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(rdata == 8'h40 && irq_n == 1, "R1 after release", {irq_n, rdata}, 9'h140);
    cmp_on = 1;

    // R11 / R2: one-cycle IPC pulse, latency of three edges
    @(negedge clk); src[1] = 1;
    @(negedge clk); src[1] = 0;
    @(negedge clk);
    check(rdata[1] == 0, "R2 latency early", rdata[1], 0);
    @(negedge clk);
    check(rdata[1] == 1, "R11 pulse latched", rdata[1], 1);
    check(irq_n == 0, "R9 IPC unmaskable", irq_n, 0);

    // R10: read access with all-ones data has no effect
    @(negedge clk); cs = 1; wr = 0; wdata = 8'hFF;
    @(negedge clk); cs = 0; wdata = 0;
    check(rdata[4:0] == 5'h02, "R10 read no clear", rdata[4:0], 5'h02);
    wr_byte(8'h00);
    check(rdata[1] == 1, "R6 zero keeps", rdata[1], 1);
    wr_byte(8'h02);
    check(rdata[4:0] == 0 && irq_n == 1, "R6 ack IPC", {irq_n, rdata[4:0]}, 6'h20);

    // R3 / R8: masked gap still reads pending
    @(negedge clk); src[0] = 1;
    @(negedge clk); src[0] = 0;
    repeat (3) @(negedge clk);
    check(rdata[0] == 1 && irq_n == 1, "R3 masked gap visible", {irq_n, rdata[0]}, 2'b11);
    wr_byte(8'h20);
    check(irq_n == 0, "R8 gap enabled", irq_n, 0);
    wr_byte(8'h00);
    check(irq_n == 1 && rdata[0] == 1, "R8 gap disabled", {irq_n, rdata[0]}, 2'b11);
    wr_byte(8'h1F);
    check(rdata[4:0] == 0, "R6 ack all", rdata[4:0], 0);

    // R7: set and clear on the same edge
    @(negedge clk); src[3] = 1;
    @(negedge clk);
    @(negedge clk); cs = 1; wr = 1; wdata = 8'h08;
    @(negedge clk); cs = 0; wr = 0; wdata = 0;
    check(rdata[3] == 1, "R7 set wins", rdata[3], 1);
    src[3] = 0;
    repeat (3) @(negedge clk);
    wr_byte(8'h08);
    check(rdata[3] == 0, "R6 frame cleared", rdata[3], 0);

    // R4 / R5: reference and motor levels
    @(negedge clk); rtc_ref = 1; motor = 2'b01;
    @(negedge clk);
    check(rdata[7:5] == 3'b010, "R4 one edge old", rdata[7:5], 3'b010);
    @(negedge clk);
    check(rdata[7:5] == 3'b001, "R5 motor active", rdata[7:5], 3'b001);
    baud_ref = 1; motor = 0;
    repeat (2) @(negedge clk);
    check(rdata[7:5] == 3'b111, "R4 baud high", rdata[7:5], 3'b111);

    // random phase compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      for (int k = 0; k < 5; k++) if ($urandom_range(9) == 0) src[k] = ~src[k];
      if ($urandom_range(3) == 0) rtc_ref = ~rtc_ref;
      baud_ref = ~baud_ref;
      if ($urandom_range(15) == 0) motor = 2'($urandom);
      cs = ($urandom_range(3) == 0);
      wr = $urandom_range(1);
      wdata = 8'($urandom);
    end
    @(negedge clk); cs = 0; wr = 0;
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule